// File: doc/BRIEF.md
# Commutation Pattern Phase Checker

This block watches a three-phase drive for a rotor that has drifted away from the commutation pattern being driven. It receives the 3-bit pattern from the rotor position sensors and the 3-bit commutation pattern that a motor-control timer is driving. On a sampling strobe, it checks whether the driven pattern is within one step of the sensed position on a fixed six-step cycle.

When the driven pattern falls outside that window, the block sets a sticky mismatch flag. It also raises a one-cycle warning interrupt. Software clears the flag by pulsing a clear input. While the mismatch lasts, the flag is set again on every clock, so a clear only takes effect once the phases agree again. Neither side is checked while it shows an illegal code. The whole check is gated by an enable bit and by a timer-running bit.

Top module: `cpc_phase_checker`

## Requirements
- R1: The six legal codes form the cycle 101, 100, 110, 010, 011, 001, then back to 101, written as bits [2:0]. A driven pattern is accepted when it equals the sensed step, the step before it or the step after it. Any other legal driven pattern is a mismatch.
- R2: A mismatch counts only in a cycle where at least one bit of `trig` is 1. With `trig` all zero, the flag is never set.
- R3: If either `sens_pat` or `drv_pat` is 000 or 111, that cycle never sets the flag.
- R4: The flag is set only when both `chk_en` and `tmr_run` are 1.
- R5: Once set, `mis_flag` stays 1 until a cycle with `clr_wr` = 1 and no mismatch. After that cycle, `mis_flag` reads 0.
- R6: A mismatch sets the flag again in every cycle it is present, so a clear has no effect during a persisting mismatch.
- R7: When a mismatch and `clr_wr` fall in the same cycle, the set wins and `mis_flag` is 1 after that edge.
- R8: `warn_irq` is 1 for exactly the one cycle in which `mis_flag` goes from 0 to 1. It stays 0 while the flag is re-set when it is already 1.
- R9: The block has a synchronous active-high `rst`. After reset, `mis_flag` and `warn_irq` are 0.
- R10: Timing: a mismatch sampled at a rising clock edge is visible on `mis_flag` and `warn_irq` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sens_pat | input | 3 | Position sensor pattern |
| drv_pat | input | 3 | Commutation pattern being driven |
| trig | input | NTRIG (2) | Sampling strobes, ORed together |
| chk_en | input | 1 | Check enable |
| tmr_run | input | 1 | Timer running |
| clr_wr | input | 1 | Clear strobe for the flag |
| mis_flag | output | 1 | Sticky mismatch flag |
| warn_irq | output | 1 | One-cycle warning interrupt |

## Verification
The two functions that can fall in the same cycle are the set from a detected mismatch and the software clear. The bench provokes this collision on purpose with directed steps: it holds a mismatch while pulsing `clr_wr`, then removes the mismatch and clears again. It also lets random stimulus produce the collision often, by driving `clr_wr` in roughly a quarter of cycles. Every cycle, the outcome is judged against a model that applies set-before-clear, and `warn_irq` is checked to pulse only on the flag's 0-to-1 edge and never on a re-set.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  localparam int PAT_W = 3;
  localparam int NSTEP = 6;
  typedef logic [PAT_W-1:0] pat_t;
  typedef logic [2:0] idx_t;

  localparam idx_t IDX_BAD = 3'd7;

  // Position of a code on the six-step cycle; IDX_BAD for 000/111.
  function automatic idx_t step_of(input pat_t p);
    case (p)
      3'b101: step_of = 3'd0;
      3'b100: step_of = 3'd1;
      3'b110: step_of = 3'd2;
      3'b010: step_of = 3'd3;
      3'b011: step_of = 3'd4;
      3'b001: step_of = 3'd5;
      default: step_of = IDX_BAD;
    endcase
  endfunction

  function automatic logic is_legal(input pat_t p);
    return step_of(p) != IDX_BAD;
  endfunction

  // Forward distance from sensed step to driven step, modulo NSTEP.
  function automatic logic [3:0] fwd_dist(input idx_t a, input idx_t b);
    logic [3:0] s;
    s = {1'b0, b} + 4'd6 - {1'b0, a};
    return (s >= 4'd6) ? s - 4'd6 : s;
  endfunction

  function automatic logic in_window(input pat_t sens, input pat_t drv);
    logic [3:0] d;
    d = fwd_dist(step_of(sens), step_of(drv));
    return (d == 4'd0) || (d == 4'd1) || (d == 4'd5);
  endfunction
endpackage

// File: rtl/cpc_window.sv
module cpc_window
  import cpc_pkg::*;
#(
  parameter int NTRIG = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  pat_t             sens_pat,
  input  pat_t             drv_pat,
  input  logic [NTRIG-1:0] trig,
  input  logic             chk_en,
  input  logic             tmr_run,
  output logic             set_evt,
  output logic             illegal_any
);
  logic [NTRIG-1:0] trig_chain;
  logic             sample;
  logic             armed;
  logic             off_window;

  // Running OR over the strobes
  generate
    for (genvar g = 0; g < NTRIG; g++) begin : g_trig
      if (g == 0) begin : g_first
        assign trig_chain[g] = trig[g];
      end else begin : g_rest
        assign trig_chain[g] = trig_chain[g-1] | trig[g];
      end
    end
  endgenerate

  assign sample      = trig_chain[NTRIG-1];
  assign armed       = chk_en & tmr_run;
  assign illegal_any = ~is_legal(sens_pat) | ~is_legal(drv_pat);
  assign off_window  = ~in_window(sens_pat, drv_pat);
  assign set_evt     = armed & sample & ~illegal_any & off_window;

  AST_ILLEGAL_IGNORED: assert property (@(posedge clk) disable iff (rst)
    illegal_any |-> !set_evt); // R3
  AST_NEEDS_TRIGGER: assert property (@(posedge clk) disable iff (rst)
    (trig == '0) |-> !set_evt); // R2
endmodule

// File: rtl/cpc_flag.sv
module cpc_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic clr_wr,
  output logic flag_q,
  output logic irq_q
);
  logic rise_evt;
  assign rise_evt = set_evt & ~flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= rise_evt;
      if (set_evt)      flag_q <= 1'b1;
      else if (clr_wr)  flag_q <= 1'b0;
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    flag_q && !clr_wr |=> flag_q); // R5
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    clr_wr && !set_evt |=> !flag_q); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> flag_q); // R7
  AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> flag_q && !$past(flag_q)); // R8
endmodule

// File: rtl/cpc_phase_checker.sv
module cpc_phase_checker
  import cpc_pkg::*;
#(
  parameter int NTRIG = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       sens_pat,
  input  logic [2:0]       drv_pat,
  input  logic [NTRIG-1:0] trig,
  input  logic             chk_en,
  input  logic             tmr_run,
  input  logic             clr_wr,
  output logic             mis_flag,
  output logic             warn_irq
);
  logic set_evt;
  logic illegal_any;

  cpc_window #(.NTRIG(NTRIG)) u_window (
    .clk(clk), .rst(rst), .sens_pat(sens_pat), .drv_pat(drv_pat),
    .trig(trig), .chk_en(chk_en), .tmr_run(tmr_run),
    .set_evt(set_evt), .illegal_any(illegal_any)
  );

  cpc_flag u_flag (
    .clk(clk), .rst(rst), .set_evt(set_evt), .clr_wr(clr_wr),
    .flag_q(mis_flag), .irq_q(warn_irq)
  );

  AST_GATED_BY_ENABLE: assert property (@(posedge clk) disable iff (rst)
    !(chk_en && tmr_run) |-> !set_evt); // R4
  AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
    warn_irq |-> $past(set_evt)); // R8
  AST_RESET_CLEAN: assert property (@(posedge clk)
    $past(rst) |-> !mis_flag && !warn_irq); // R9
endmodule

// File: tb/tb_cpc_phase_checker.sv
module tb_cpc_phase_checker;
  localparam int CLK_PERIOD = 10;
  localparam int NTRIG = 2;
  localparam int NRAND = 4000;

  logic clk = 1'b0;
  logic rst;
  logic [2:0] sens_pat, drv_pat;
  logic [NTRIG-1:0] trig;
  logic chk_en, tmr_run, clr_wr;
  logic mis_flag, warn_irq;

  int n_chk = 0, n_fail = 0;
  logic exp_flag, exp_irq;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpc_phase_checker #(.NTRIG(NTRIG)) dut (
    .clk(clk), .rst(rst), .sens_pat(sens_pat), .drv_pat(drv_pat),
    .trig(trig), .chk_en(chk_en), .tmr_run(tmr_run), .clr_wr(clr_wr),
    .mis_flag(mis_flag), .warn_irq(warn_irq)
  );

  // Cycle order used by the model, looked up by search.
  localparam logic [2:0] RING [6] = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};

  function automatic int pos(input logic [2:0] p);
    for (int i = 0; i < 6; i++) if (RING[i] == p) return i;
    return -1;
  endfunction

  function automatic bit model_mismatch(input logic [2:0] s, input logic [2:0] d);
    int a, b;
    a = pos(s); b = pos(d);
    if (a < 0 || b < 0) return 0;
    return !(d == RING[a] || d == RING[(a + 1) % 6] || d == RING[(a + 5) % 6]);
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Drive inputs, take one edge, update the model, then compare.
  task automatic step(input logic [2:0] s, input logic [2:0] d, input logic [NTRIG-1:0] t,
                      input logic en, input logic run, input logic clr, input string req);
    bit setc;
    sens_pat = s; drv_pat = d; trig = t; chk_en = en; tmr_run = run; clr_wr = clr;
    @(posedge clk);
    setc = en && run && (t != 0) && model_mismatch(s, d);
    exp_irq = setc && !exp_flag;
    if (setc) exp_flag = 1'b1;
    else if (clr) exp_flag = 1'b0;
    #(CLK_PERIOD/4);
    check(req, mis_flag, exp_flag, "mis_flag");
    check(req, warn_irq, exp_irq, "warn_irq");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    process::self().srandom(32'd4711);
    rst = 1'b1; sens_pat = 3'b101; drv_pat = 3'b101; trig = '0;
    chk_en = 0; tmr_run = 0; clr_wr = 0;
    exp_flag = 0; exp_irq = 0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R9", mis_flag, 1'b0, "mis_flag after reset");
    check("R9", warn_irq, 1'b0, "warn_irq after reset");
    rst = 1'b0;
    // R1: in-window neighbours accepted
    step(3'b101, 3'b001, 2'b01, 1, 1, 0, "R1");
    step(3'b101, 3'b100, 2'b10, 1, 1, 0, "R1");
    step(3'b100, 3'b110, 2'b11, 1, 1, 0, "R1");
    // R2: mismatch without strobe
    step(3'b101, 3'b110, 2'b00, 1, 1, 0, "R2");
    // R3: illegal codes on each side
    step(3'b000, 3'b110, 2'b01, 1, 1, 0, "R3");
    step(3'b101, 3'b111, 2'b01, 1, 1, 0, "R3");
    // R4: enable gating
    step(3'b101, 3'b110, 2'b01, 0, 1, 0, "R4");
    step(3'b101, 3'b110, 2'b01, 1, 0, 0, "R4");
    // R1/R8/R10: mismatch sets flag with one irq pulse
    step(3'b101, 3'b110, 2'b01, 1, 1, 0, "R8");
    step(3'b101, 3'b110, 2'b10, 1, 1, 0, "R8");
    // R6/R7: clear during persisting mismatch loses
    step(3'b101, 3'b110, 2'b01, 1, 1, 1, "R7");
    step(3'b011, 3'b101, 2'b01, 1, 1, 1, "R6");
    // R5: sticky, then clear once agreed
    step(3'b011, 3'b011, 2'b01, 1, 1, 0, "R5");
    step(3'b011, 3'b011, 2'b01, 1, 1, 1, "R5");
    step(3'b011, 3'b011, 2'b00, 1, 1, 0, "R5");
    // R8: fresh rise after clear gives new pulse
    step(3'b010, 3'b001, 2'b10, 1, 1, 1, "R8");
    // random mix, illegal codes included
    for (int i = 0; i < NRAND; i++) begin
      logic [2:0] rs, rd;
      rs = 3'($urandom);
      rd = ($urandom_range(0, 2) == 0) ? 3'($urandom) : RING[$urandom_range(0, 5)];
      step(rs, rd, NTRIG'($urandom), $urandom_range(0, 7) != 0, $urandom_range(0, 7) != 0,
           $urandom_range(0, 3) == 0, "R1");
    end
    finish_run();
  end
endmodule